// File: doc/BRIEF.md
# Two-Wire Wiper Setting Slave

This block is a two-wire serial bus slave that owns a single 7-bit wiper setting, as used to steer a digitally controlled resistor ladder. SCL and SDA are sampled in a faster system clock domain. The block finds START and STOP conditions, matches one fixed 7-bit device address and then either takes data bytes into the wiper setting or returns the current setting to the bus master. SDA is driven only through an open-drain enable, where a 1 pulls the line low.

No command byte and no register index exist. Every data byte of a write transaction goes straight into the setting. Every byte of a read transaction returns the setting, with a zero in its top bit. Downstream logic receives the setting as a parallel code, along with a one-cycle strobe each time a write lands.

The system clock must run at least eight times faster than SCL. The block never holds SCL low.

Top module: `i2c_wiper_slave`

## Requirements
- R1: One system clock after reset, the wiper code is 0x40 (midscale), the SDA pull-down enable is 0 and the update strobe is 0.
- R2: The first byte after a START is the address, sent MSB first: seven address bits 0101110, then a direction bit (0 = write, 1 = read). On a match, the slave pulls SDA low while SCL is high in the ninth clock.
- R3: If the address does not match, the slave does not pull SDA low at any point up to the next START. No data byte that follows changes the wiper code.
- R4: In a write, each data byte is sent MSB first. Bit 7 is ignored, bits 6..0 become the new wiper code, and the slave pulls SDA low in the ninth clock of that byte.
- R5: Within one write transaction, every data byte after the address updates the wiper code again, in order, until STOP.
- R6: The wiper code changes only in a cycle in which the update strobe is high. The strobe lasts one system clock and fires once per accepted write byte.
- R7: In a read, each byte sends a 0 first and then bits 6..0 of the current code, MSB first. A master ACK (SDA low in the ninth clock) starts another byte. A master NACK (SDA high) ends the read, and the slave then leaves SDA released.
- R8: A repeated START in the middle of a byte drops that partial byte without touching the wiper code and restarts address reception.
- R9: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| wiper_code_o | output | 7 | Current wiper setting |
| wiper_update_o | output | 1 | One-cycle strobe when a new setting is loaded |

## Verification
A wrong bit counter or a wrong state shows up on SDA within one byte time. The acknowledge moves to the wrong clock or disappears, or read data shifts by a bit position. Either one is visible at the master's next ninth clock. A corrupted wiper setting or shift register shows up on the next read, which returns a byte different from the last value written. A stray or missing update is caught at once, because the scoreboard pops one expected code for each strobe and checks that the queue is empty at the end.

// File: rtl/wsl_pkg.sv
package wsl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_DATA,
    ST_WR_ACK,
    ST_RD_DATA,
    ST_RD_ACK,
    ST_IGNORE
  } wsl_state_e;
endpackage

// File: rtl/wsl_line_sync.sv
module wsl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-1:0], din};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];
  assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/wsl_frontend.sv
module wsl_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  localparam int N_LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [N_LINES-1:0] raw, lvl, up, dn;
  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    wsl_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[g]),
      .level(lvl[g]),
      .rise (up[g]),
      .fall (dn[g])
    );
  end

  assign scl_s    = lvl[0];
  assign scl_rise = up[0];
  assign scl_fall = dn[0];
  assign sda_s    = lvl[1];
  // SCL must be high and settled (not just risen) for a bus condition
  assign start_det = dn[1] & lvl[0] & ~up[0];
  assign stop_det  = up[1] & lvl[0] & ~up[0];
endmodule

// File: rtl/wsl_wiper_reg.sv
module wsl_wiper_reg #(
  parameter int                 CODE_W     = 7,
  parameter logic [CODE_W-1:0]  RESET_CODE = 7'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code,
  output logic              update
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code   <= RESET_CODE;
      update <= 1'b0;
    end else begin
      update <= wr_en;
      if (wr_en) code <= wr_data;
    end
  end
endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave
  import wsl_pkg::*;
#(
  parameter int                CODE_W      = 7,
  parameter logic [6:0]        DEV_ADDR    = 7'b0101110,
  parameter logic [CODE_W-1:0] RESET_CODE  = 7'h40,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [CODE_W-1:0] wiper_code_o,
  output logic              wiper_update_o
);
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, scl_rise, scl_fall, sda_s, start_det, stop_det;

  wsl_frontend #(.SYNC_STAGES(SYNC_STAGES)) i_frontend (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  wsl_state_e         state;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  rx_sh;
  logic [BYTE_W-2:0]  tx_rest;   // bits still to send after the one on the bus
  logic               rd_dir;
  logic               m_ack;
  logic               byte_done;
  logic               wr_en;
  logic [BYTE_W-1:0]  tx_load;

  assign byte_done = scl_fall && (bit_cnt == LAST_BIT);
  assign wr_en     = (state == ST_WR_DATA) && byte_done && !start_det && !stop_det;
  assign tx_load   = BYTE_W'(wiper_code_o);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_rest  <= '0;
      rd_dir   <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_ADDR;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR_DATA: begin
          if (scl_rise) begin
            rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            bit_cnt <= '0;
            if (state == ST_WR_DATA) begin
              state    <= ST_WR_ACK;
              sda_oe_o <= 1'b1;
            end else if (rx_sh[BYTE_W-1 -: ADDR_W] == DEV_ADDR) begin
              state    <= ST_ADDR_ACK;
              rd_dir   <= rx_sh[0];
              sda_oe_o <= 1'b1;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_dir) begin
              state    <= ST_RD_DATA;
              sda_oe_o <= ~tx_load[BYTE_W-1];
              tx_rest  <= tx_load[BYTE_W-2:0];
            end else begin
              state    <= ST_WR_DATA;
              sda_oe_o <= 1'b0;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state    <= ST_WR_DATA;
            sda_oe_o <= 1'b0;
          end
        end
        ST_RD_DATA: begin
          if (scl_rise) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (byte_done) begin
            state    <= ST_RD_ACK;
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
          end else if (scl_fall) begin
            sda_oe_o <= ~tx_rest[BYTE_W-2];
            tx_rest  <= {tx_rest[BYTE_W-3:0], 1'b0};
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (m_ack) begin
              state    <= ST_RD_DATA;
              sda_oe_o <= ~tx_load[BYTE_W-1];
              tx_rest  <= tx_load[BYTE_W-2:0];
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;  // idle and ignore wait for a bus condition
      endcase
    end
  end

  wsl_wiper_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) i_wiper (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_data(rx_sh[CODE_W-1:0]),
    .code   (wiper_code_o),
    .update (wiper_update_o)
  );
endmodule

// File: rtl/wsl_checker.sv
module wsl_checker
  import wsl_pkg::*;
#(
  parameter int                CODE_W     = 7,
  parameter logic [CODE_W-1:0] RESET_CODE = 7'h40
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_oe,
  input logic [CODE_W-1:0] wiper_code,
  input logic              wiper_update,
  input wsl_state_e        state
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      AST_RESET_STATE: assert (wiper_code == RESET_CODE && !sda_oe && !wiper_update); // R1
    end
  end

  AST_IGNORE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe); // R3

  AST_WRITE_ACK_DRIVEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR_ACK) |-> sda_oe); // R4

  AST_CODE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(wiper_code) |-> wiper_update); // R6

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wiper_update |=> !wiper_update); // R6

  AST_NACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD_ACK) |-> !sda_oe); // R7

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s)); // R9
endmodule

bind i2c_wiper_slave wsl_checker #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) i_wsl_checker (
  .clk         (clk),
  .rst         (rst),
  .scl_s       (scl_s),
  .sda_oe      (sda_oe_o),
  .wiper_code  (wiper_code_o),
  .wiper_update(wiper_update_o),
  .state       (state)
);

// File: tb/test_i2c_wiper_slave.sv
module test_i2c_wiper_slave;
  localparam int Q = 10;                 // clocks per SCL quarter phase
  localparam logic [6:0] DEV = 7'b0101110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [6:0] code;
  logic upd;
  wire  sda_bus = m_sda & ~sda_oe;

  always #10 clk = ~clk;                 // 50 MHz

  i2c_wiper_slave i_i2c_wiper_slave (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl),
    .sda_i         (sda_bus),
    .sda_oe_o      (sda_oe),
    .wiper_code_o  (code),
    .wiper_update_o(upd)
  );

  int checks = 0;
  int errors = 0;
  int oe_seen = 0;
  bit done = 1'b0;
  logic [6:0] exp_q[$];
  logic [6:0] model = 7'h40;
  logic [6:0] exp_item;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // scoreboard monitor: every strobe must match the oldest expected code
  always @(negedge clk) begin
    if (sda_oe) oe_seen++;
    if (!rst && upd) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected update actual=0x%0h expected=none", code);
      end else begin
        exp_item = exp_q.pop_front();
        if (code !== exp_item) begin
          errors++;
          $display("FAIL R4: update code actual=0x%0h expected=0x%0h", code, exp_item);
        end
      end
    end
  end

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; w(Q);
    scl = 1'b1;   w(Q);
    m_sda = 1'b0; w(Q);
    scl = 1'b0;   w(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; w(Q);
    scl = 1'b1;   w(Q);
    m_sda = 1'b1; w(Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; w(Q);
    scl = 1'b1; w(Q);
    scl = 1'b0; w(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; w(Q);
    scl = 1'b1; w(Q / 2);
    b = sda_bus; w(Q - Q / 2);
    scl = 1'b0; w(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = (a == 1'b0);
  endtask

  task automatic get_byte(output logic [7:0] v, input bit give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(give_ack ? 1'b0 : 1'b1);
  endtask

  // driver: a data byte to the device, with the expected code pushed first
  task automatic drive_data(input logic [7:0] v, input string req);
    bit a;
    exp_q.push_back(v[6:0]);
    model = v[6:0];
    put_byte(v, a);
    chk(a, req, 0, 1);
  endtask

  task automatic read_check(input int nbytes, input string req);
    bit a;
    logic [7:0] v;
    bus_start();
    put_byte({DEV, 1'b1}, a);
    chk(a, "R2 read address ack", 0, 1);
    for (int i = 0; i < nbytes; i++) begin
      get_byte(v, i != nbytes - 1);
      chk(v == {1'b0, model}, req, v, {1'b0, model});
    end
    w(2 * Q);
    chk(sda_oe == 1'b0, "R7 released after NACK", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    bit a;
    w(5);
    rst = 1'b0;
    @(negedge clk);
    chk(code == 7'h40, "R1 reset code", code, 7'h40);
    chk(sda_oe == 1'b0, "R1 reset sda drive", sda_oe, 0);
    chk(upd == 1'b0, "R1 reset strobe", upd, 0);
    w(4 * Q);

    // R1: readback of midscale
    read_check(1, "R1 midscale readback");

    // R2 R4: single write, then readback
    bus_start();
    put_byte({DEV, 1'b0}, a);
    chk(a, "R2 write address ack", 0, 1);
    drive_data(8'h15, "R4 data ack");
    bus_stop();
    read_check(1, "R4 readback 0x15");

    // R4: bit 7 ignored
    bus_start();
    put_byte({DEV, 1'b0}, a);
    chk(a, "R2 write address ack", 0, 1);
    drive_data(8'hEA, "R4 data ack msb set");
    bus_stop();
    read_check(1, "R4 readback msb dropped");

    // R5: several bytes in one transaction, extremes
    bus_start();
    put_byte({DEV, 1'b0}, a);
    chk(a, "R2 write address ack", 0, 1);
    drive_data(8'h7F, "R5 byte 1 ack");
    drive_data(8'h00, "R5 byte 2 ack");
    drive_data(8'h5A, "R5 byte 3 ack");
    bus_stop();
    chk(exp_q.size() == 0, "R5 all updates seen", exp_q.size(), 0);
    // R7: repeated read with master acks
    read_check(3, "R7 repeated read");

    // R3: foreign address, no drive, no update
    oe_seen = 0;
    bus_start();
    put_byte({7'b0101111, 1'b0}, a);
    chk(!a, "R3 no ack foreign address", a, 0);
    put_byte(8'h22, a);
    chk(!a, "R3 no ack foreign data", a, 0);
    bus_stop();
    chk(oe_seen == 0, "R3 sda never driven", oe_seen, 0);
    read_check(1, "R3 code unchanged");

    // R8: repeated start mid byte drops the partial byte
    bus_start();
    put_byte({DEV, 1'b0}, a);
    chk(a, "R2 write address ack", 0, 1);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    bus_start();
    put_byte({DEV, 1'b0}, a);
    chk(a, "R8 address ack after restart", 0, 1);
    drive_data(8'h33, "R8 data ack after restart");
    bus_stop();
    read_check(1, "R8 readback after restart");

    w(4 * Q);
    chk(exp_q.size() == 0, "R6 no missing update", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule